// File: doc/BRIEF.md
# Nibble-Addressed Divider Programming Port

This block takes divider settings for a dual-modulus frequency synthesiser from a microprocessor bus that is only four bits wide. Software writes eight 4-bit words. A 3-bit select addresses each word, and a level-sensitive strobe writes it. The words build up a staging rank that holds three values: the main count M (10 bits), the swallow count A (7 bits) and the reference count R (11 bits).

Staged values do not reach the dividers until word 0 is written. That write copies the whole staging rank into the working rank on a single clock edge, including the nibble it carries. One cycle later the block raises a reload pulse, so the divider counters clear to zero and restart from the new values. Software therefore writes word 0 last.

The strobe, select and data inputs come from another clock domain and are synchronised inside the block. A write commits when the block detects the falling edge of the strobe. The data used is the last data seen while the strobe was high.

Top module: `synth_prog_if`

## Requirements
- R1: During and after reset, all three staged values and all working outputs are zero, and `reload_o` is low.
- R2: Words 0, 1 and 2 carry M bits [3:0], [7:4] and [9:8]. For word 2, M[9:8] comes from data bits [1:0]. Data bit 3 is the MSB of each nibble.
- R3: Words 3 and 4 carry A bits [3:0] and [6:4], with A[6:4] from data bits [2:0]. Words 5, 6 and 7 carry R bits [3:0], [7:4] and [10:8], with R[10:8] from data bits [2:0]. Data bits with no field position in words 2, 4 and 7 have no effect on any output.
- R4: A word commits on the detected falling edge of the strobe. It uses the select and data last sampled while the strobe was high, so data that changes while the strobe is high resolves to its final value.
- R5: While the strobe is low, changes on the select and data inputs have no effect on any output.
- R6: Writing any word other than word 0 leaves `m_o`, `a_o`, `r_o` and `reload_o` unchanged.
- R7: Committing word 0 updates `m_o`, `a_o` and `r_o` together on one edge, three clock edges after the first low strobe sample. The new word-0 nibble is included in that update.
- R8: A staged R below 3 appears on `r_o` as 3. Values from 3 to 2047 pass unchanged.
- R9: `reload_o` is high for exactly one cycle, the cycle after the working outputs update. It is never high at any other time.
- R10: Writing word 0 again with no other change repeats the reload pulse and keeps the same working values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Write strobe, level sensitive, asynchronous |
| sel_i | input | 3 | Word select |
| data_i | input | 4 | Nibble data, bit 3 is the MSB |
| m_o | output | 10 | Working main count |
| a_o | output | 7 | Working swallow count |
| r_o | output | 11 | Working reference count, at least 3 |
| reload_o | output | 1 | One-cycle counter clear-and-reload pulse |

## Verification
Committing word 0 does two things on the same edge: it writes a staging nibble and it transfers the whole rank. The working value must therefore include the nibble that arrives in that same write. The bench provokes this by staging everything except the low M nibble and then writing word 0 with a fresh value. It judges the result by comparing `m_o` in every cycle against a behavioural model that merges the nibble before it copies the rank. The clamp takes effect on the same transfer edge; the bench writes R values of 1, 2, 4 and 2047 to check that `r_o` jumps straight to the clamped value.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned NIB_W_DEF  = 4;
  localparam int unsigned SEL_W_DEF  = 3;
  localparam int unsigned M_W_DEF    = 10;
  localparam int unsigned A_W_DEF    = 7;
  localparam int unsigned R_W_DEF    = 11;
  localparam int unsigned R_MIN_DEF  = 3;
  localparam int unsigned SYNC_DEF   = 2;
  localparam int unsigned XFER_WORD  = 0;

  function automatic int unsigned words_for(int unsigned bits, int unsigned nib);
    return (bits + nib - 1) / nib;
  endfunction
endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NIB_W-1:0] dat_i,
  output logic             commit_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [NIB_W-1:0] dat_o
);
  logic             stb_prev_q;
  logic [SEL_W-1:0] hold_sel_q;
  logic [NIB_W-1:0] hold_dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_prev_q <= 1'b0;
      hold_sel_q <= '0;
      hold_dat_q <= '0;
    end else begin
      stb_prev_q <= stb_i;
      // last value seen while strobe high wins
      if (stb_i) begin
        hold_sel_q <= sel_i;
        hold_dat_q <= dat_i;
      end
    end
  end

  assign commit_o = stb_prev_q & ~stb_i;
  assign sel_o    = hold_sel_q;
  assign dat_o    = hold_dat_q;
endmodule

// File: rtl/field_rank.sv
module field_rank #(
  parameter int unsigned W     = 10,
  parameter int unsigned BASE  = 0,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NIB_W-1:0] dat_i,
  output logic [W-1:0]     rank_o,
  output logic [W-1:0]     next_o
);
  logic [W-1:0] rank_q;

  // bit b of the field lives in word BASE + b/NIB_W, position b%NIB_W
  always_comb begin
    next_o = rank_q;
    for (int b = 0; b < int'(W); b++) begin
      if (wr_i && sel_i == SEL_W'(int'(BASE) + b / int'(NIB_W)))
        next_o[b] = dat_i[b % int'(NIB_W)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rank_q <= '0;
    else         rank_q <= next_o;
  end

  assign rank_o = rank_q;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int unsigned NIB_W       = NIB_W_DEF,
  parameter int unsigned SEL_W       = SEL_W_DEF,
  parameter int unsigned M_W         = M_W_DEF,
  parameter int unsigned A_W         = A_W_DEF,
  parameter int unsigned R_W         = R_W_DEF,
  parameter int unsigned R_MIN       = R_MIN_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NIB_W-1:0] data_i,
  output logic [M_W-1:0]   m_o,
  output logic [A_W-1:0]   a_o,
  output logic [R_W-1:0]   r_o,
  output logic             reload_o
);
  localparam int unsigned M_BASE = 0;
  localparam int unsigned A_BASE = M_BASE + words_for(M_W, NIB_W);
  localparam int unsigned R_BASE = A_BASE + words_for(A_W, NIB_W);
  localparam int unsigned IN_W   = 1 + SEL_W + NIB_W;

  logic [IN_W-1:0]  raw_in, syn_in;
  logic             stb_s;
  logic [SEL_W-1:0] sel_s, cap_sel;
  logic [NIB_W-1:0] dat_s, cap_dat;
  logic             commit, xfer;
  logic [M_W-1:0]   m_stage, m_next;
  logic [A_W-1:0]   a_stage, a_next;
  logic [R_W-1:0]   r_stage, r_next, r_clamped;
  logic [M_W-1:0]   m_q;
  logic [A_W-1:0]   a_q;
  logic [R_W-1:0]   r_q;
  logic             xfer_q, reload_q;

  assign raw_in = {strobe_i, sel_i, data_i};
  assign {stb_s, sel_s, dat_s} = syn_in;

  sync_stage #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(syn_in)
  );

  strobe_capture #(.SEL_W(SEL_W), .NIB_W(NIB_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_s), .sel_i(sel_s), .dat_i(dat_s),
    .commit_o(commit), .sel_o(cap_sel), .dat_o(cap_dat)
  );

  field_rank #(.W(M_W), .BASE(M_BASE), .NIB_W(NIB_W), .SEL_W(SEL_W)) u_m_rank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(commit), .sel_i(cap_sel), .dat_i(cap_dat),
    .rank_o(m_stage), .next_o(m_next)
  );

  field_rank #(.W(A_W), .BASE(A_BASE), .NIB_W(NIB_W), .SEL_W(SEL_W)) u_a_rank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(commit), .sel_i(cap_sel), .dat_i(cap_dat),
    .rank_o(a_stage), .next_o(a_next)
  );

  field_rank #(.W(R_W), .BASE(R_BASE), .NIB_W(NIB_W), .SEL_W(SEL_W)) u_r_rank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(commit), .sel_i(cap_sel), .dat_i(cap_dat),
    .rank_o(r_stage), .next_o(r_next)
  );

  assign xfer      = commit && (cap_sel == SEL_W'(XFER_WORD));
  assign r_clamped = (r_next < R_W'(R_MIN)) ? R_W'(R_MIN) : r_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q      <= '0;
      a_q      <= '0;
      r_q      <= '0;
      xfer_q   <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      // transfer uses merged next values so the word-0 nibble lands too
      if (xfer) begin
        m_q <= m_next;
        a_q <= a_next;
        r_q <= r_clamped;
      end
      xfer_q   <= xfer;
      reload_q <= xfer_q;
    end
  end

  assign m_o      = m_q;
  assign a_o      = a_q;
  assign r_o      = r_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int unsigned M_W   = 10,
  parameter int unsigned A_W   = 7,
  parameter int unsigned R_W   = 11,
  parameter int unsigned R_MIN = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [M_W-1:0] m_o,
  input logic [A_W-1:0] a_o,
  input logic [R_W-1:0] r_o,
  input logic           reload_o
);
  AST_RELOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !reload_o); // R9

  AST_CHANGE_THEN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({m_o, a_o, r_o}) |=> reload_o); // R7

  AST_STABLE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> $stable({m_o, a_o, r_o})); // R9

  AST_R_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> (r_o >= R_W'(R_MIN))); // R8
endmodule

bind synth_prog_if synth_prog_if_chk #(
  .M_W(M_W), .A_W(A_W), .R_W(R_W), .R_MIN(R_MIN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m_o(m_o), .a_o(a_o), .r_o(r_o), .reload_o(reload_o)
);

// File: tb/sim_synth_prog_if.sv
module sim_synth_prog_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [2:0]  sel = '0;
  logic [3:0]  data = '0;
  logic [9:0]  m_o;
  logic [6:0]  a_o;
  logic [10:0] r_o;
  logic        reload_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  synth_prog_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .sel_i(sel), .data_i(data),
    .m_o(m_o), .a_o(a_o), .r_o(r_o), .reload_o(reload_o)
  );

  // behavioural model: inputs seen after 2-stage sync, commit on seen fall
  int hs[$], hsel[$], hdat[$];
  int wrd [8];
  int exp_m = 0, exp_a = 0, exp_r = 0;
  bit exp_reload = 0, fire_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs.delete(); hsel.delete(); hdat.delete();
      for (int i = 0; i < 8; i++) wrd[i] = 0;
      exp_m = 0; exp_a = 0; exp_r = 0; exp_reload = 0; fire_prev = 0;
    end else begin
      bit fire_now;
      fire_now = 0;
      hs.push_back(int'(strobe)); hsel.push_back(int'(sel)); hdat.push_back(int'(data));
      if (hs.size() > 4) begin
        void'(hs.pop_front()); void'(hsel.pop_front()); void'(hdat.pop_front());
      end
      exp_reload = fire_prev;
      if (hs.size() == 4 && hs[0] == 1 && hs[1] == 0) begin
        wrd[hsel[0]] = hdat[0];
        if (hsel[0] == 0) begin
          fire_now = 1;
          exp_m = wrd[0] + 16 * wrd[1] + 256 * (wrd[2] % 4);
          exp_a = wrd[3] + 16 * (wrd[4] % 8);
          exp_r = wrd[5] + 16 * wrd[6] + 256 * (wrd[7] % 8);
          if (exp_r < 3) exp_r = 3;
        end
      end
      fire_prev = fire_now;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 m_o vs model", int'(m_o), exp_m);
      chk("R3 a_o vs model", int'(a_o), exp_a);
      chk("R8 r_o vs model", int'(r_o), exp_r);
      chk("R9 reload_o vs model", int'(reload_o), int'(exp_reload));
    end
  end

  task automatic put_word(int s, int d);
    @(negedge clk); sel = 3'(s); data = 4'(d); strobe = 1'b1;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // write word 0 and measure the timing of update and pulse
  task automatic fire_word0(int d, output int upd_at, output int rel_at, output int rel_cnt);
    int m_before;
    m_before = int'(m_o);
    upd_at = -1; rel_at = -1; rel_cnt = 0;
    @(negedge clk); sel = 3'd0; data = 4'(d); strobe = 1'b1;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (upd_at < 0 && int'(m_o) != m_before) upd_at = i;
      if (reload_o) begin
        rel_cnt++;
        if (rel_at < 0) rel_at = i;
      end
    end
  endtask

  initial begin
    int ua, ra, rc;
    repeat (3) @(negedge clk);
    chk("R1 m_o in reset", int'(m_o), 0);
    chk("R1 reload_o in reset", int'(reload_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 r_o after reset", int'(r_o), 0);
    chk("R1 a_o after reset", int'(a_o), 0);

    // stage M=0x2A5 A=0x5B R=0x3E8 with stray upper bits in partial words
    put_word(1, 4'hA); put_word(2, 4'hE);
    put_word(3, 4'hB); put_word(4, 4'hD);
    put_word(5, 4'h8); put_word(6, 4'hE); put_word(7, 4'hB);
    chk("R6 m_o unchanged before word 0", int'(m_o), 0);
    chk("R6 r_o unchanged before word 0", int'(r_o), 0);

    fire_word0(4'h5, ua, ra, rc);
    chk("R7 m_o merged with new nibble", int'(m_o), 'h2A5);
    chk("R3 a_o upper bit ignored", int'(a_o), 'h5B);
    chk("R3 r_o upper bit ignored", int'(r_o), 'h3E8);
    chk("R7 update three edges after fall", ua, 3);
    chk("R9 pulse in cycle after update", ra, 4);
    chk("R9 pulse width one", rc, 1);

    // inputs wiggle with strobe low
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sel = 3'(i); data = 4'(15 - i);
    end
    repeat (6) @(negedge clk);
    chk("R5 m_o unchanged strobe low", int'(m_o), 'h2A5);
    chk("R5 reload_o low strobe low", int'(reload_o), 0);

    // data changing during a long strobe: last value wins
    @(negedge clk); sel = 3'd0; data = 4'h1; strobe = 1'b1;
    @(negedge clk); data = 4'h2;
    @(negedge clk); data = 4'h3;
    @(negedge clk); strobe = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 last nibble while high", int'(m_o), 'h2A3);

    // M nibble order
    put_word(1, 4'h2); put_word(2, 4'h1);
    fire_word0(4'h3, ua, ra, rc);
    chk("R2 nibble order", int'(m_o), 'h123);

    // reference clamp boundaries
    put_word(5, 1); put_word(6, 0); put_word(7, 0);
    fire_word0(4'h3, ua, ra, rc);
    chk("R8 r=1 clamps to 3", int'(r_o), 3);
    put_word(5, 2);
    fire_word0(4'h3, ua, ra, rc);
    chk("R8 r=2 clamps to 3", int'(r_o), 3);
    put_word(5, 4);
    fire_word0(4'h3, ua, ra, rc);
    chk("R8 r=4 passes", int'(r_o), 4);
    put_word(5, 4'hF); put_word(6, 4'hF); put_word(7, 4'h7);
    fire_word0(4'h3, ua, ra, rc);
    chk("R8 r=2047 passes", int'(r_o), 2047);

    // repeated word 0 with no change
    fire_word0(4'h3, ua, ra, rc);
    chk("R10 repeat pulse count", rc, 1);
    chk("R10 repeat pulse timing", ra, 4);
    chk("R10 m_o kept", int'(m_o), 'h123);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    miscompares++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule